// File: doc/BRIEF.md
# Configurable Byte Swizzle Unit

The unit rearranges the bytes of a 128-bit vector. Each of its sixteen byte lanes has an 8-bit index in the index vector. That index names the data byte that appears in the same lane of the result. The unit is a pure datapath: one result per accepted input, with no flow control and no internal state apart from an optional output register.

Indices that fall outside the first vector can be treated in three ways, chosen per operation by a 2-bit mode input:

- **Zeroing:** any index at or above the lane count yields a zero byte.
- **High-bit:** an index with its top bit set yields zero, and any other index wraps modulo the lane count.
- **Two-source:** the low five bits of the index choose one of 32 bytes, taken from two concatenated vectors.

Feeding the same vector to both sources in two-source mode gives plain modulo selection. A parameter selects between a combinational path and a path with one register stage. The register stage suits clocked pipelines that need a short critical path.

Top module: `byte_swizzle_unit`

## Requirements
- R1: In every mode, an index value k in 0..15 places byte k of `vec_a` into the lane that holds the index.
- R2: With `mode` = 2'b00 (zeroing), any index in 16..255 produces 8'h00 in its lane.
- R3: With `mode` = 2'b01 (high-bit), an index with bit 7 set produces 8'h00. Any other index produces byte (index mod 16) of `vec_a`.
- R4: With `mode` = 2'b10 (two-source), only index bits [4:0] are used. Values 0..15 take byte k of `vec_a`, values 16..31 take byte k-16 of `vec_b`, and bits [7:5] have no effect.
- R5: In two-source mode with `vec_b` equal to `vec_a`, every lane equals byte (index mod 16) of `vec_a`.
- R6: `mode` = 2'b11 gives exactly the zeroing result of R2 and R1.
- R7: Byte lane n occupies bits [8n+7:8n] of `vec_a`, `vec_b`, `idx_vec` and `out_vec`.
- R8: With `REG_OUT` = 1, `out_vec` and `out_valid` show the result and `in_valid` from exactly one clock edge earlier. While `rst` is high, both outputs are cleared to zero.
- R9: With `REG_OUT` = 0, `out_vec` and `out_valid` follow the inputs in the same cycle with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the inputs as a valid operation |
| mode | input | 2 | Out-of-range policy: 00 zeroing, 01 high-bit, 10 two-source, 11 zeroing |
| vec_a | input | 128 | First data vector, lane n in bits [8n+7:8n] |
| vec_b | input | 128 | Second data vector, used by two-source mode |
| idx_vec | input | 128 | Sixteen 8-bit lane indices |
| out_valid | output | 1 | Valid flag aligned with `out_vec` |
| out_vec | output | 128 | Permuted result vector |

## Verification
The bench builds the unit twice with the default 16 lanes of 8 bits:

- **`REG_OUT` = 1:** brings the one-edge latency, reset clearing and valid alignment within reach.
- **`REG_OUT` = 0:** lets the same stimulus check the combinational path within the cycle.

Because the index byte is only 8 bits wide, a sweep can walk all 256 index values through every lane in every mode, including the reserved one. The lane index is offset by a per-lane stride, so every lane sees every value. Directed vectors then pin down the values at each policy boundary, the byte layout, and the equal-sources case of two-source mode.

// File: rtl/swz_pkg.sv
`timescale 1ns/1ps
package swz_pkg;

  typedef enum logic [1:0] {
    SWZ_ZERO  = 2'b00,
    SWZ_HIBIT = 2'b01,
    SWZ_PAIR  = 2'b10,
    SWZ_RSVD  = 2'b11
  } swz_mode_e;

endpackage

// File: rtl/swz_policy.sv
`timescale 1ns/1ps
// Turns one lane index plus the mode into a slot number, a source choice
// and a kill flag that forces the lane to zero.
module swz_policy #(
  parameter int LANES = 16,
  parameter int IDX_W = 8,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] idx,
  output logic [SEL_W-1:0] slot,
  output logic             take_b,
  output logic             kill
);
  import swz_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  swz_mode_e mode_e;
  assign mode_e = swz_mode_e'(mode);

  always_comb begin
    slot   = idx[SEL_W-1:0];
    take_b = 1'b0;
    kill   = 1'b0;
    case (mode_e)
      SWZ_HIBIT: kill   = idx[IDX_W-1];
      SWZ_PAIR:  take_b = idx[SEL_W];
      default:   kill   = (idx > LAST_IDX);
    endcase
  end

endmodule

// File: rtl/swz_lane_pick.sv
`timescale 1ns/1ps
// One output lane: decode the index policy, then pick a byte.
module swz_lane_pick #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 8,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic [1:0]                   mode,
  input  logic [IDX_W-1:0]             idx,
  input  logic [LANES-1:0][LANE_W-1:0] src_a,
  input  logic [LANES-1:0][LANE_W-1:0] src_b,
  output logic [LANE_W-1:0]            lane_out
);

  logic [SEL_W-1:0]  slot;
  logic              take_b;
  logic              kill;
  logic [LANE_W-1:0] byte_a;
  logic [LANE_W-1:0] byte_b;

  swz_policy #(.LANES(LANES), .IDX_W(IDX_W)) u_policy (
    .mode   (mode),
    .idx    (idx),
    .slot   (slot),
    .take_b (take_b),
    .kill   (kill)
  );

  assign byte_a = src_a[slot];
  assign byte_b = src_b[slot];

  always_comb begin
    if (kill)
      lane_out = '0;
    else if (take_b)
      lane_out = byte_b;
    else
      lane_out = byte_a;
  end

endmodule

// File: rtl/swz_out_stage.sv
`timescale 1ns/1ps
// Optional output register, chosen by REG_OUT.
module swz_out_stage #(
  parameter int DATA_W  = 128,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic [DATA_W-1:0] d_data,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data
);

  generate
    if (REG_OUT) begin : g_reg
      logic              valid_r;
      logic [DATA_W-1:0] data_r;

      always_ff @(posedge clk) begin
        if (rst) begin
          valid_r <= 1'b0;
          data_r  <= '0;
        end else begin
          valid_r <= d_valid;
          data_r  <= d_data;
        end
      end

      assign q_valid = valid_r;
      assign q_data  = data_r;

      // R8
      valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        d_valid |=> q_valid);
      // R8
      valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !d_valid |=> !q_valid);
      // R8
      data_delay_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q_data == $past(d_data)));
    end else begin : g_comb
      assign q_valid = d_valid;
      assign q_data  = d_data;
    end
  endgenerate

endmodule

// File: rtl/byte_swizzle_unit.sv
`timescale 1ns/1ps
module byte_swizzle_unit #(
  parameter int LANES   = 16,
  parameter int LANE_W  = 8,
  parameter int IDX_W   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int VEC_W  = LANES * LANE_W,
  localparam int IVEC_W = LANES * IDX_W,
  localparam int SEL_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [VEC_W-1:0]  vec_a,
  input  logic [VEC_W-1:0]  vec_b,
  input  logic [IVEC_W-1:0] idx_vec,
  output logic              out_valid,
  output logic [VEC_W-1:0]  out_vec
);
  import swz_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);

  logic [LANES-1:0][LANE_W-1:0] src_a;
  logic [LANES-1:0][LANE_W-1:0] src_b;
  logic [LANES-1:0][LANE_W-1:0] picked;

  assign src_a = vec_a;
  assign src_b = vec_b;

  generate
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
      logic [IDX_W-1:0] lane_idx;
      assign lane_idx = idx_vec[gi*IDX_W +: IDX_W];

      swz_lane_pick #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_pick (
        .mode     (mode),
        .idx      (lane_idx),
        .src_a    (src_a),
        .src_b    (src_b),
        .lane_out (picked[gi])
      );

      // R2
      zero_mode_blank_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode == SWZ_ZERO || mode == SWZ_RSVD) && lane_idx > LAST_IDX)
          |-> (picked[gi] == '0));
      // R3
      hibit_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SWZ_HIBIT && lane_idx[IDX_W-1]) |-> (picked[gi] == '0));
      // R4
      pair_low_half_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SWZ_PAIR && !lane_idx[SEL_W])
          |-> (picked[gi] == vec_a[lane_idx[SEL_W-1:0]*LANE_W +: LANE_W]));
      // R5
      pair_same_src_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SWZ_PAIR && vec_a == vec_b)
          |-> (picked[gi] == vec_a[lane_idx[SEL_W-1:0]*LANE_W +: LANE_W]));
    end
  endgenerate

  swz_out_stage #(.DATA_W(VEC_W), .REG_OUT(REG_OUT)) u_out (
    .clk     (clk),
    .rst     (rst),
    .d_valid (in_valid),
    .d_data  (picked),
    .q_valid (out_valid),
    .q_data  (out_vec)
  );

endmodule

// File: tb/byte_swizzle_unit_bench.sv
`timescale 1ns/1ps
module byte_swizzle_unit_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [127:0] vec_a = '0;
  logic [127:0] vec_b = '0;
  logic [127:0] idx_vec = '0;
  logic         out_valid;
  logic [127:0] out_vec;
  logic         c_valid;
  logic [127:0] c_vec;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  byte_swizzle_unit #(.REG_OUT(1'b1)) u_byte_swizzle_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .vec_a(vec_a), .vec_b(vec_b), .idx_vec(idx_vec),
    .out_valid(out_valid), .out_vec(out_vec));

  byte_swizzle_unit #(.REG_OUT(1'b0)) u_byte_swizzle_unit_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .vec_a(vec_a), .vec_b(vec_b), .idx_vec(idx_vec),
    .out_valid(c_valid), .out_vec(c_vec));

  function automatic logic [127:0] ref_vec(input int m, input logic [127:0] a,
                                           input logic [127:0] b, input logic [127:0] s);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 16; i++) begin
      int ix;
      int t;
      ix = int'(s[i*8 +: 8]);
      if (m == 1) begin
        if (ix < 128) r[i*8 +: 8] = a[(ix % 16)*8 +: 8];
      end else if (m == 2) begin
        t = ix % 32;
        r[i*8 +: 8] = (t < 16) ? a[t*8 +: 8] : b[(t-16)*8 +: 8];
      end else begin
        if (ix < 16) r[i*8 +: 8] = a[ix*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic check_vec(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  // Drive one operation; check the combinational copy in-cycle (R9) and the
  // registered copy one edge later (R8).
  task automatic apply(input string tag, input int m, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] s,
                       input logic v, input logic [127:0] exp);
    @(negedge clk);
    mode = 2'(m); vec_a = a; vec_b = b; idx_vec = s; in_valid = v;
    #1;
    check_vec({tag, " R9 comb"}, c_vec, exp);
    check_bit({tag, " R9 comb valid"}, c_valid, v);
    @(posedge clk);
    #1;
    check_vec({tag, " R8 reg"}, out_vec, exp);
    check_bit({tag, " R8 reg valid"}, out_valid, v);
  endtask

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] s;
    logic [127:0] ident;
    string tags [4];
    int dir_idx [7];
    tags[0] = "R2 sweep"; tags[1] = "R3 sweep"; tags[2] = "R4 sweep"; tags[3] = "R6 sweep";
    dir_idx = '{0, 15, 16, 31, 127, 128, 255};

    // R8 reset state, with stimulus present during reset
    in_valid = 1'b1; vec_a = '1; idx_vec = '0;
    repeat (3) @(posedge clk);
    #1;
    check_bit("R8 reset valid", out_valid, 1'b0);
    check_vec("R8 reset data", out_vec, '0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;

    // R7 byte layout: lane n holds value n, identity and reversed indices
    for (int i = 0; i < 16; i++) ident[i*8 +: 8] = 8'(i);
    apply("R7 identity", 0, ident, '0, ident, 1'b1, ident);
    for (int i = 0; i < 16; i++) s[i*8 +: 8] = 8'(15 - i);
    for (int i = 0; i < 16; i++) b[i*8 +: 8] = 8'(15 - i);
    apply("R7 reverse", 0, ident, '0, s, 1'b1, b);
    apply("R8 invalid", 0, ident, '0, ident, 1'b0, ident);

    // R1 in-range indices in every mode, with a distinct vec_b
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 16; i++) begin
        a[i*8 +: 8] = 8'(8'hC0 + i*3);
        b[i*8 +: 8] = 8'(8'h11 * i + 1);
        s[i*8 +: 8] = 8'((i * 7) % 16);
      end
      apply("R1 in-range", m, a, b, s, 1'b1, ref_vec(m, a, b, s));
    end

    // Directed boundary indices, same value in all lanes (R2 R3 R4 R6)
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 7; d++) begin
        for (int i = 0; i < 16; i++) begin
          a[i*8 +: 8] = 8'(8'h20 + i);
          b[i*8 +: 8] = 8'(8'h90 + i);
          s[i*8 +: 8] = 8'(dir_idx[d]);
        end
        apply({tags[m], " directed"}, m, a, b, s, 1'b1, ref_vec(m, a, b, s));
      end
    end

    // Sweep: every index value reaches every lane in every mode
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 256; v++) begin
        for (int i = 0; i < 16; i++) begin
          s[i*8 +: 8] = 8'(v + i*17);
          a[i*8 +: 8] = 8'(i*37 + v + 1);
          b[i*8 +: 8] = 8'(i*53 + v*3 + 129);
        end
        apply(tags[m], m, a, b, s, 1'((v % 3) != 0), ref_vec(m, a, b, s));
      end
    end

    // R5 equal sources in two-source mode match modulo-16 selection
    for (int v = 0; v < 256; v++) begin
      for (int i = 0; i < 16; i++) begin
        s[i*8 +: 8] = 8'(v + i*29);
        a[i*8 +: 8] = 8'(i*41 + v*5 + 7);
      end
      for (int i = 0; i < 16; i++)
        b[i*8 +: 8] = a[(int'(s[i*8 +: 8]) % 16)*8 +: 8];
      apply("R5 same-src", 2, a, a, s, 1'b1, b);
    end

    // R8 reset mid-stream clears outputs
    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    @(posedge clk);
    #1;
    check_bit("R8 mid reset valid", out_valid, 1'b0);
    check_vec("R8 mid reset data", out_vec, '0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule